// File: doc/BRIEF.md
# Four-Mode Serial Peripheral Master

This block is a master for a synchronous serial peripheral bus. It runs one exchange session at a time. A host offers a transmit word on a valid/ready command port, together with the clock polarity, the clock phase and the bit order for that session. While the block is idle, `cmd_ready` is high and a word is taken on any cycle where `cmd_valid` and `cmd_ready` are both high. While a session runs, `cmd_ready` is low and the port applies back-pressure: a `cmd_valid` raised during that time is dropped, not queued. The host must hold the word until it sees ready.

Once a word is accepted, the block drives the active-low select line low and waits one half-period. It then toggles the serial clock `2*DATA_W` times. A single shift register sends the word on `mosi` and, in the same register, collects the reply arriving on `miso`. After one more half-period the block raises select, copies the reply to `rx_data` and raises `rx_valid` for one cycle. The result port has no ready: the host must take the word on the pulse, and the word then stays in `rx_data` until the next session ends. Each half-period of the serial clock lasts `HALF_CYC` system clocks, and `HALF_CYC` must be at least 2.

Top module: `spi_xfer_master`

## Requirements
- R1: While idle, `sclk` rests at the polarity level. The idle level follows `cfg_cpol` one cycle later: it is low for polarity 0 and high for polarity 1. The first edge of a session leaves that level, and `sclk` is back at it when select rises.
- R2: With phase 0, `mosi` already carries the first bit when select falls, at least one half-period before the first clock edge. Both sides sample on each leading (odd-numbered) edge and change data on each trailing edge.
- R3: With phase 1, data changes on each leading edge and both sides sample on each trailing edge.
- R4: `mosi` never changes in the same cycle as a sampling edge of `sclk`.
- R5: Each session has exactly `2*DATA_W` clock edges. The mode number is {cpol, cpha}, and in all four modes the full duplex works: the slave receives `cmd_data` and `rx_data` becomes the slave's word.
- R6: When `cfg_lsb_first` is 1, bit 0 is sent and received first. When it is 0, bit `DATA_W-1` is sent and received first. The same order applies on both data lines.
- R7: `cs_n` falls in the cycle after the command is accepted and rises once per session. Every session opens with a fresh falling edge.
- R8: Between successive `sclk` edges of a session there are exactly `HALF_CYC` system clocks.
- R9: `rx_valid` is high for exactly one cycle. Select has already been high for at least one cycle when it rises. `rx_data` holds its value after the pulse.
- R10: `cmd_ready` is low for the whole session. A `cmd_valid` during a session neither changes the session nor starts a new one.
- R11: During reset, `cs_n` is 1, `cmd_ready` is 1, `rx_valid` is 0 and `mosi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Transmit word offered |
| cmd_ready | output | 1 | Block idle, word will be taken |
| cmd_data | input | DATA_W | Word to transmit |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: top bit first |
| rx_valid | output | 1 | One-cycle pulse, received word ready |
| rx_data | output | DATA_W | Last received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low session select |

## Verification
The bench sweeps all four modes and both bit orders against a behavioural slave, using words that are asymmetric in their bit positions. A design that confused leading and trailing edges, or dropped the final shift in phase 1, would return a word shifted by one bit. A reversed or half-applied bit order would mirror the word in one direction only. The bench also times every half-period and the gap from select to the first edge, counts the edges per session, and checks the clock level at idle and when select rises. Finally, it offers a second word in the middle of a session and checks that this word neither corrupts the result nor opens an extra session.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN,
    ST_HOLD,
    ST_FIN
  } xfer_state_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } xfer_cfg_t;

endpackage

// File: rtl/spi_xfer_clkdiv.sv
module spi_xfer_clkdiv #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              load_lsb,
  input  logic              sample_en,
  input  logic              shift_en,
  input  logic              miso,
  output logic              out_bit,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] sr_next;
  logic              lat;
  logic              lsb_q;

  // One register serves both directions: the outgoing end feeds mosi,
  // and the captured bit enters at the opposite end.
  always_comb begin
    if (lsb_q) begin
      sr_next = {lat, sr[DATA_W-1:1]};
    end else begin
      sr_next = {sr[DATA_W-2:0], lat};
    end
  end

  assign out_bit = lsb_q ? sr[0] : sr[DATA_W-1];
  assign word    = sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr    <= '0;
      lat   <= 1'b0;
      lsb_q <= 1'b0;
    end else if (load) begin
      sr    <= load_word;
      lsb_q <= load_lsb;
      lat   <= 1'b0;
    end else begin
      if (sample_en) lat <= miso;
      if (shift_en)  sr  <= sr_next;
    end
  end
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_req,
  input  xfer_cfg_t cfg_in,
  input  logic      tick,
  output logic      idle,
  output logic      div_run,
  output logic      load,
  output logic      sample_en,
  output logic      shift_en,
  output logic      capture,
  output logic      sclk,
  output logic      cs_n,
  output xfer_cfg_t cfg_q
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES);
  localparam logic [EC_W-1:0] EDGE_LAST = EC_W'(EDGES - 1);

  xfer_state_t      state;
  logic [EC_W-1:0]  ec;
  logic             lead;
  logic             run_tick;
  logic             is_sample;

  assign idle      = (state == ST_IDLE);
  assign div_run   = !idle;
  assign load      = idle && start_req;
  assign capture   = (state == ST_FIN);
  assign lead      = !ec[0];
  assign run_tick  = (state == ST_RUN) && tick;
  // Sampling edge: leading edge for phase 0, trailing edge for phase 1.
  assign is_sample = lead ^ cfg_q.cpha;
  assign sample_en = run_tick && is_sample;
  // Change edges shift, except the very first leading edge of phase 1,
  // whose bit is already presented from load. Phase 1 owes one last
  // shift after its final trailing sample.
  assign shift_en  = (run_tick && !is_sample && !(lead && (ec == '0)))
                   || ((state == ST_HOLD) && tick && cfg_q.cpha);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sclk  <= 1'b0;
      cs_n  <= 1'b1;
      ec    <= '0;
      cfg_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          sclk <= cfg_in.cpol;
          if (start_req) begin
            cfg_q <= cfg_in;
            cs_n  <= 1'b0;
            ec    <= '0;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tick) state <= ST_RUN;
        end
        ST_RUN: begin
          if (tick) begin
            sclk <= !sclk;
            ec   <= ec + 1'b1;
            if (ec == EDGE_LAST) state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            cs_n  <= 1'b1;
            state <= ST_FIN;
          end
        end
        ST_FIN: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  xfer_cfg_t         cfg_in;
  xfer_cfg_t         cfg_q;
  logic              tick;
  logic              div_run;
  logic              load;
  logic              sample_en;
  logic              shift_en;
  logic              capture;
  logic              out_bit;
  logic [DATA_W-1:0] word;
  logic              cur_cpol;
  logic              cur_cpha;

  assign cfg_in   = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};
  assign cur_cpol = cfg_q.cpol;
  assign cur_cpha = cfg_q.cpha;

  spi_xfer_clkdiv #(.HALF_CYC(HALF_CYC)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (div_run),
    .tick  (tick)
  );

  spi_xfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (cmd_valid),
    .cfg_in    (cfg_in),
    .tick      (tick),
    .idle      (cmd_ready),
    .div_run   (div_run),
    .load      (load),
    .sample_en (sample_en),
    .shift_en  (shift_en),
    .capture   (capture),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .cfg_q     (cfg_q)
  );

  spi_xfer_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (cmd_data),
    .load_lsb  (cfg_lsb_first),
    .sample_en (sample_en),
    .shift_en  (shift_en),
    .miso      (miso),
    .out_bit   (out_bit),
    .word      (word)
  );

  assign mosi = cs_n ? 1'b0 : out_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= capture;
      if (capture) rx_data <= word;
    end
  end
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic cmd_ready,
  input logic cfg_cpol,
  input logic rx_valid,
  input logic cur_cpol,
  input logic cur_cpha
);
  AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd_ready) && cmd_ready) |-> (sclk == $past(cfg_cpol))); // R1

  AST_CLK_HOME_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (sclk == cur_cpol)); // R1

  AST_MOSI_HOLD_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !cs_n && !$past(cs_n) && (sclk != $past(sclk))
      && ((sclk ^ cur_cpol) != cur_cpha)) |-> $stable(mosi)); // R4

  AST_HALF_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !cs_n && (sclk != $past(sclk))) |=> $stable(sclk)); // R8

  AST_DONE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (cs_n && $past(cs_n))); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !cmd_ready); // R10
endmodule

bind spi_xfer_master spi_xfer_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .cmd_ready (cmd_ready),
  .cfg_cpol  (cfg_cpol),
  .rx_valid  (rx_valid),
  .cur_cpol  (cur_cpol),
  .cur_cpha  (cur_cpha)
);

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb;
  localparam int W    = 8;
  localparam int HALF = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [W-1:0] cmd_data = '0;
  logic         cfg_cpol = 1'b0;
  logic         cfg_cpha = 1'b0;
  logic         cfg_lsb_first = 1'b0;
  logic         rx_valid;
  logic [W-1:0] rx_data;
  logic         sclk;
  logic         mosi;
  logic         miso = 1'b0;
  logic         cs_n;

  int checks = 0, errors = 0;
  int s_checks = 0, s_errors = 0;
  bit finished = 0;

  logic [W-1:0] sl_word = '0;
  logic [W-1:0] sl_rcv = '0;
  int           cs_falls = 0;

  always #5 clk = ~clk;

  spi_xfer_master #(.DATA_W(W), .HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .rx_valid(rx_valid), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic schk(input bit ok, input string req, input int act, input int exp);
    s_checks++;
    if (!ok) begin
      s_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitpos(input int i, input bit lsb);
    return lsb ? i : (W - 1 - i);
  endfunction

  // Behavioural slave, evaluated away from the active edge.
  initial begin
    logic sclk_prev, cs_prev;
    int   k, cyc, last_evt, gap, idx;
    bit   lead;
    sclk_prev = 1'b0; cs_prev = 1'b1; k = 0; cyc = 0; last_evt = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (cs_prev && !cs_n) begin
          cs_falls++;
          k = 0;
          sl_rcv = '0;
          last_evt = cyc;
          miso = sl_word[bitpos(0, cfg_lsb_first)];
          schk(sclk == cfg_cpol, "R1 clock level at open", sclk, cfg_cpol);
        end else if (!cs_n && (sclk != sclk_prev)) begin
          gap = cyc - last_evt;
          last_evt = cyc;
          if (k == 0) begin
            schk(gap >= HALF, "R2 select to first edge", gap, HALF);
            schk(sclk != cfg_cpol, "R1 first edge leaves idle", sclk, !cfg_cpol);
          end else begin
            schk(gap == HALF, "R8 half period", gap, HALF);
          end
          lead = (k % 2 == 0);
          if (lead != cfg_cpha) begin
            sl_rcv[bitpos(k / 2, cfg_lsb_first)] = mosi;
          end else if (cfg_cpha) begin
            miso = sl_word[bitpos(k / 2, cfg_lsb_first)];
          end else begin
            idx = (k + 1) / 2;
            if (idx < W) miso = sl_word[bitpos(idx, cfg_lsb_first)];
          end
          k++;
        end
        if (!cs_prev && cs_n) begin
          schk(k == 2 * W, "R5 edges per session", k, 2 * W);
          schk(sclk == cfg_cpol, "R1 clock home at close", sclk, cfg_cpol);
        end
      end
      sclk_prev = sclk;
      cs_prev = cs_n;
    end
  end

  task automatic run_xfer(input bit pol, input bit pha, input bit lsb,
                          input logic [W-1:0] tx, input logic [W-1:0] sw);
    int t;
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; sl_word = sw;
    repeat (2) @(negedge clk);
    chk(sclk == pol, "R1 idle level follows polarity", sclk, pol);
    chk(cmd_ready == 1'b1, "R10 ready when idle", cmd_ready, 1);
    cmd_data = tx; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cs_n == 1'b0, "R7 select falls after accept", cs_n, 0);
    chk(cmd_ready == 1'b0, "R10 busy drops ready", cmd_ready, 0);
    t = 0;
    while (!rx_valid && t < 500) begin @(negedge clk); t++; end
    chk(rx_valid == 1'b1, "R9 done pulse seen", rx_valid, 1);
    chk(rx_data == sw, lsb ? "R6 lsb-first receive" : "R5 msb-first receive", rx_data, sw);
    chk(sl_rcv == tx, pha ? "R3 slave got word" : "R2 slave got word", sl_rcv, tx);
    chk(cs_n == 1'b1, "R9 select high at done", cs_n, 1);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R9 pulse one cycle", rx_valid, 0);
    chk(rx_data == sw, "R9 data held", rx_data, sw);
  endtask

  initial begin
    int falls0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R11 reset select", cs_n, 1);
    chk(cmd_ready == 1'b1, "R11 reset ready", cmd_ready, 1);
    chk(rx_valid == 1'b0, "R11 reset done", rx_valid, 0);
    chk(mosi == 1'b0, "R11 reset mosi", mosi, 0);
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 2; o++) begin
        for (int w = 0; w < 4; w++) begin
          logic [W-1:0] tx, sw;
          tx = W'((w * 73 + m * 29 + o * 101 + 1) & 255);
          sw = ~tx ^ W'((w * 17 + m * 5) & 255);
          run_xfer(m[1], m[0], o[0], tx, sw);
        end
      end
    end

    // R10: a command offered mid-session is dropped.
    falls0 = cs_falls;
    @(negedge clk);
    cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; sl_word = 8'h3C;
    cmd_data = 8'hA5; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (8) @(negedge clk);
    cmd_data = 8'hFF; cmd_valid = 1'b1;
    chk(cmd_ready == 1'b0, "R10 ready low mid-session", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data = 8'h00;
    while (!rx_valid) @(negedge clk);
    chk(rx_data == 8'h3C, "R10 result unaffected", rx_data, 8'h3C);
    chk(sl_rcv == 8'hA5, "R10 sent word unaffected", sl_rcv, 8'hA5);
    repeat (30) @(negedge clk);
    chk(cs_falls == falls0 + 1, "R7 R10 one session only", cs_falls, falls0 + 1);
    chk(cs_n == 1'b1, "R10 no session opened", cs_n, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors + s_errors, checks + s_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors + s_errors + 1, checks + s_checks + 1);
      $finish;
    end
  end
endmodule